// File: doc/BRIEF.md
# Dual-Bank Processor Register File

This block stores the programmer-visible general registers of a 16-bit microcontroller core. Seven 16-bit registers are banked: four data registers (R0..R3), two address registers (A0, A1) and a frame base (FB). Two full copies of these seven exist, and a registered bank flag decides which copy every banked access reaches. Three 16-bit registers are shared by both banks and never switch: the static base (SB), the user stack pointer (USP) and the interrupt stack pointer (ISP). A registered stack flag picks which of the two stack pointers answers the "active stack pointer" selector.

Every port names a register with a 4-bit selector and a 2-bit access size. The size is one of byte, word or long. Byte accesses reach the low and high halves of R0 and R1. Long accesses reach three register pairs, and the upper half always comes first in the read value. The file has two combinational read ports and one write port. Writes are committed on the rising clock edge and are not forwarded to reads in the same cycle.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears all 17 registers to zero, sets `bank_o` to 0 and sets `usp_o` to 0, which selects ISP.
- R2: Word access (size 2'd1) uses selectors 0..9 for R0, R1, R2, R3, A0, A1, FB, SB, USP and ISP. A word read returns the 16-bit value zero-extended to 32 bits. A word write replaces the whole register.
- R3: Byte access (size 2'd0) uses selector 0 for R0 low, 1 for R0 high, 2 for R1 low and 3 for R1 high. A byte read returns the 8 bits zero-extended. A byte write takes `wr_data[7:0]` and leaves the other byte of the register unchanged.
- R4: Long access (size 2'd2) uses selector 0 for R2:R0, 1 for R3:R1 and 2 for A1:A0, with the first-named register in bits 31:16. A long write updates both halves at the same edge, and a long read returns both halves from the active bank.
- R5: `bank_sel_i` is sampled at a rising edge and becomes the active bank (`bank_o`) after that edge. A write in the same cycle as a bank change goes to the bank that was active before the change.
- R6: The bank that is not active keeps its contents. Reads and writes never touch it.
- R7: SB, USP and ISP do not depend on the bank. Their values are the same whichever bank is active.
- R8: Word selector 10 names the active stack pointer: USP when `usp_o` is 1 and ISP when it is 0. `usp_sel_i` is sampled at a rising edge and takes effect after that edge.
- R9: Both read ports are combinational and independent. A read of the register being written in the same cycle returns the value from before the write.
- R10: Size 2'd3, and any selector outside the ranges above, reads as zero. A write with such a size or selector changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel_i | input | 1 | Requested bank, applied after the edge |
| usp_sel_i | input | 1 | Requested stack pointer (1 = USP), applied after the edge |
| wr_en | input | 1 | Write enable |
| wr_size | input | 2 | Write access size |
| wr_sel | input | 4 | Write register selector |
| wr_data | input | 32 | Write data |
| ra_size | input | 2 | Read port A access size |
| ra_sel | input | 4 | Read port A selector |
| ra_data | output | 32 | Read port A data |
| rb_size | input | 2 | Read port B access size |
| rb_sel | input | 4 | Read port B selector |
| rb_data | output | 32 | Read port B data |
| bank_o | output | 1 | Active bank |
| usp_o | output | 1 | Active stack pointer flag (1 = USP) |

## Verification
Two events can land in the same cycle: a bank switch and a write, or a stack flag switch and a write to selector 10. In either case the write must reach the old bank or the old stack pointer. The bench forces these collisions directly, then keeps provoking them with random stimulus, and reads the stored value back after the switch from both banks. A behavioural model holds separate arrays for each bank. On every cycle it predicts both read ports and the two flags, and compares them before the edge, which also checks that same-cycle writes are not forwarded.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  localparam int WORD_W     = 16;
  localparam int BANK_REGS  = 7;
  localparam int SHR_REGS   = 3;
  localparam int SLOTS      = BANK_REGS + SHR_REGS;
  localparam int SEL_W      = 4;
  localparam int RD_W       = 2 * WORD_W;
  localparam int HALF_W     = WORD_W / 2;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  localparam logic [SEL_W-1:0] SEL_ACTIVE_SP = SEL_W'(SLOTS);
  localparam logic [SEL_W-1:0] SLOT_USP      = SEL_W'(BANK_REGS + 1);
  localparam logic [SEL_W-1:0] SLOT_ISP      = SEL_W'(BANK_REGS + 2);

  typedef logic [SLOTS-1:0][WORD_W-1:0] slot_vec_t;

  function automatic logic [SEL_W-1:0] sp_slot(input logic use_usp);
    return use_usp ? SLOT_USP : SLOT_ISP;
  endfunction

  function automatic slot_vec_t wr_mask_f(input logic en, input logic [1:0] size,
                                          input logic [SEL_W-1:0] sel, input logic use_usp);
    slot_vec_t m;
    m = '0;
    if (en) begin
      case (size)
        SZ_BYTE: begin
          case (sel)
            4'd0: m[0] = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            4'd1: m[0] = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
            4'd2: m[1] = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            4'd3: m[1] = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
            default: ;
          endcase
        end
        SZ_WORD: begin
          if (sel < SEL_W'(SLOTS)) m[sel] = '1;
          else if (sel == SEL_ACTIVE_SP) m[sp_slot(use_usp)] = '1;
        end
        SZ_LONG: begin
          case (sel)
            4'd0: begin m[0] = '1; m[2] = '1; end
            4'd1: begin m[1] = '1; m[3] = '1; end
            4'd2: begin m[4] = '1; m[5] = '1; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    return m;
  endfunction

  function automatic slot_vec_t wr_val_f(input logic [1:0] size, input logic [RD_W-1:0] d);
    slot_vec_t v;
    for (int i = 0; i < SLOTS; i++) begin
      if (size == SZ_BYTE) v[i] = {d[HALF_W-1:0], d[HALF_W-1:0]};
      else                 v[i] = d[WORD_W-1:0];
    end
    if (size == SZ_LONG) begin
      v[2] = d[RD_W-1:WORD_W];
      v[3] = d[RD_W-1:WORD_W];
      v[5] = d[RD_W-1:WORD_W];
    end
    return v;
  endfunction

  function automatic logic [RD_W-1:0] rd_value_f(input logic [1:0] size, input logic [SEL_W-1:0] sel,
                                                 input slot_vec_t w, input logic use_usp);
    logic [RD_W-1:0] r;
    r = '0;
    case (size)
      SZ_BYTE: begin
        case (sel)
          4'd0: r = RD_W'(w[0][HALF_W-1:0]);
          4'd1: r = RD_W'(w[0][WORD_W-1:HALF_W]);
          4'd2: r = RD_W'(w[1][HALF_W-1:0]);
          4'd3: r = RD_W'(w[1][WORD_W-1:HALF_W]);
          default: ;
        endcase
      end
      SZ_WORD: begin
        if (sel < SEL_W'(SLOTS)) r = RD_W'(w[sel]);
        else if (sel == SEL_ACTIVE_SP) r = RD_W'(w[sp_slot(use_usp)]);
      end
      SZ_LONG: begin
        case (sel)
          4'd0: r = {w[2], w[0]};
          4'd1: r = {w[3], w[1]};
          4'd2: r = {w[5], w[4]};
          default: ;
        endcase
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode
  import regfile_pkg::*;
(
  input  logic                 wr_en,
  input  logic [1:0]           wr_size,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [RD_W-1:0]      wr_data,
  input  logic                 use_usp,
  output slot_vec_t            slot_mask,
  output slot_vec_t            slot_val
);

  always_comb begin
    slot_mask = wr_mask_f(wr_en, wr_size, wr_sel, use_usp);
    slot_val  = wr_val_f(wr_size, wr_data);
  end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int N_REGS = 7,
  parameter int W      = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [N_REGS-1:0][W-1:0]  wr_mask,
  input  logic [N_REGS-1:0][W-1:0]  wr_val,
  output logic [N_REGS-1:0][W-1:0]  q
);

  localparam int HW = W / 2;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)     q[i] <= '0;
      else if (en) q[i] <= (q[i] & ~wr_mask[i]) | (wr_val[i] & wr_mask[i]);
    end

    AST_HIGH_BYTE_KEPT: assert property (@(posedge clk) disable iff (rst)
      (wr_mask[i][W-1:HW] == '0) |=> $stable(q[i][W-1:HW])); // R3
    AST_LOW_BYTE_KEPT: assert property (@(posedge clk) disable iff (rst)
      (wr_mask[i][HW-1:0] == '0) |=> $stable(q[i][HW-1:0])); // R3
  end

  AST_IDLE_STORE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q)); // R6

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import regfile_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [SEL_W-1:0] sel,
  input  slot_vec_t        words,
  input  logic             use_usp,
  output logic [RD_W-1:0]  data
);

  always_comb data = rd_value_f(size, sel, words, use_usp);

  AST_BYTE_ZERO_EXT: assert final (size != SZ_BYTE || data[RD_W-1:HALF_W] == '0); // R3

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regfile_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bank_sel_i,
  input  logic        usp_sel_i,
  input  logic        wr_en,
  input  logic [1:0]  wr_size,
  input  logic [3:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  ra_size,
  input  logic [3:0]  ra_sel,
  output logic [31:0] ra_data,
  input  logic [1:0]  rb_size,
  input  logic [3:0]  rb_sel,
  output logic [31:0] rb_data,
  output logic        bank_o,
  output logic        usp_o
);

  localparam int N_BANKS = 2;
  localparam int N_PORTS = 2;

  logic bank_q;
  logic usp_q;

  slot_vec_t slot_mask;
  slot_vec_t slot_val;
  slot_vec_t visible;

  logic [BANK_REGS-1:0][WORD_W-1:0] bank_words [N_BANKS];
  logic [SHR_REGS-1:0][WORD_W-1:0]  shared_q;
  logic [N_BANKS-1:0]               bank_live;

  logic [1:0]       rp_size [N_PORTS];
  logic [SEL_W-1:0] rp_sel  [N_PORTS];
  logic [RD_W-1:0]  rp_data [N_PORTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= 1'b0;
      usp_q  <= 1'b0;
    end else begin
      bank_q <= bank_sel_i;
      usp_q  <= usp_sel_i;
    end
  end

  rf_write_decode u_dec (
    .wr_en     (wr_en),
    .wr_size   (wr_size),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .use_usp   (usp_q),
    .slot_mask (slot_mask),
    .slot_val  (slot_val)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_live[b] = (bank_q == 1'(b));
    rf_store #(.N_REGS(BANK_REGS), .W(WORD_W)) u_store (
      .clk     (clk),
      .rst     (rst),
      .en      (bank_live[b]),
      .wr_mask (slot_mask[BANK_REGS-1:0]),
      .wr_val  (slot_val[BANK_REGS-1:0]),
      .q       (bank_words[b])
    );
  end

  rf_store #(.N_REGS(SHR_REGS), .W(WORD_W)) u_shared (
    .clk     (clk),
    .rst     (rst),
    .en      (1'b1),
    .wr_mask (slot_mask[SLOTS-1:BANK_REGS]),
    .wr_val  (slot_val[SLOTS-1:BANK_REGS]),
    .q       (shared_q)
  );

  always_comb visible = {shared_q, bank_q ? bank_words[1] : bank_words[0]};

  assign rp_size[0] = ra_size;
  assign rp_sel[0]  = ra_sel;
  assign rp_size[1] = rb_size;
  assign rp_sel[1]  = rb_sel;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    rf_read_port u_rd (
      .size    (rp_size[p]),
      .sel     (rp_sel[p]),
      .words   (visible),
      .use_usp (usp_q),
      .data    (rp_data[p])
    );
  end

  assign ra_data = rp_data[0];
  assign rb_data = rp_data[1];
  assign bank_o  = bank_q;
  assign usp_o   = usp_q;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!bank_o && !usp_o && visible == '0 && bank_words[0] == '0 && bank_words[1] == '0)); // R1
  AST_LONG_BOTH_HALVES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == SZ_LONG && wr_sel == 4'd2 && !bank_q)
    |=> (bank_words[0][5] == $past(wr_data[31:16]) && bank_words[0][4] == $past(wr_data[15:0]))); // R4
  AST_WRITE_USES_OLD_BANK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == SZ_WORD && wr_sel == 4'd0 && !bank_q && bank_sel_i)
    |=> (bank_words[0][0] == $past(wr_data[15:0]))); // R5
  AST_OTHER_SP_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == SZ_WORD && wr_sel == SEL_ACTIVE_SP && !usp_q) |=> $stable(shared_q[1])); // R8
  AST_BAD_SIZE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_size == 2'd3) |=> ($stable(bank_words[0]) && $stable(bank_words[1]) && $stable(shared_q))); // R10

endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_sel_i = 1'b0, usp_sel_i = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_size = 2'd1, ra_size = 2'd1, rb_size = 2'd1;
  logic [3:0]  wr_sel = '0, ra_sel = '0, rb_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] ra_data, rb_data;
  logic        bank_o, usp_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural model: m_bank[bank][0..6] = R0 R1 R2 R3 A0 A1 FB ; m_sb, m_usp, m_isp
  logic [15:0] m_bank [2][7];
  logic [15:0] m_sb, m_usp, m_isp;
  logic        m_bk, m_u;

  always #(CLK_P/2) clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst), .bank_sel_i(bank_sel_i), .usp_sel_i(usp_sel_i),
    .wr_en(wr_en), .wr_size(wr_size), .wr_sel(wr_sel), .wr_data(wr_data),
    .ra_size(ra_size), .ra_sel(ra_sel), .ra_data(ra_data),
    .rb_size(rb_size), .rb_sel(rb_sel), .rb_data(rb_data),
    .bank_o(bank_o), .usp_o(usp_o)
  );

  function automatic logic [15:0] m_word(input int idx);
    if (idx < 7)  return m_bank[m_bk][idx];
    if (idx == 7) return m_sb;
    if (idx == 8) return m_usp;
    if (idx == 9) return m_isp;
    return m_u ? m_usp : m_isp;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] sz, input logic [3:0] s);
    int k = int'(s);
    if (sz == 2'd0 && k < 4)  return {24'h0, k[0] ? m_word(k / 2) >> 8 : m_word(k / 2) & 16'h00FF};
    if (sz == 2'd1 && k < 11) return {16'h0, m_word(k)};
    if (sz == 2'd2 && k == 0) return {m_word(2), m_word(0)};
    if (sz == 2'd2 && k == 1) return {m_word(3), m_word(1)};
    if (sz == 2'd2 && k == 2) return {m_word(5), m_word(4)};
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [1:0] sz, input logic [3:0] s);
    if (m_read(sz, s) == 32'h0 && (sz == 2'd3 || (sz == 2'd0 && s > 3) || (sz == 2'd2 && s > 2) || s > 10)) return "R10";
    if (sz == 2'd0) return "R3";
    if (sz == 2'd2) return "R4";
    if (s == 4'd10) return "R8";
    if (s > 4'd6)   return "R7";
    return m_bk ? "R6" : "R2";
  endfunction

  task automatic m_put(input int idx, input logic [15:0] v, input logic [15:0] keep);
    logic [15:0] old;
    if (idx == 10) idx = m_u ? 8 : 9;
    old = (idx < 7) ? m_bank[m_bk][idx] : (idx == 7) ? m_sb : (idx == 8) ? m_usp : m_isp;
    v = (old & keep) | (v & ~keep);
    if (idx < 7) m_bank[m_bk][idx] = v;
    else if (idx == 7) m_sb = v;
    else if (idx == 8) m_usp = v;
    else m_isp = v;
  endtask

  task automatic m_clock();
    int k = int'(wr_sel);
    if (rst) begin
      for (int b = 0; b < 2; b++) for (int r = 0; r < 7; r++) m_bank[b][r] = '0;
      m_sb = '0; m_usp = '0; m_isp = '0; m_bk = 0; m_u = 0;
      return;
    end
    if (wr_en) begin
      if (wr_size == 2'd0 && k < 4)
        m_put(k / 2, {wr_data[7:0], wr_data[7:0]}, k[0] ? 16'h00FF : 16'hFF00);
      else if (wr_size == 2'd1 && k < 11)
        m_put(k, wr_data[15:0], 16'h0000);
      else if (wr_size == 2'd2 && k < 3) begin
        m_put(k == 2 ? 4 : k, wr_data[15:0], 16'h0000);
        m_put(k == 2 ? 5 : k + 2, wr_data[31:16], 16'h0000);
      end
    end
    m_bk = bank_sel_i;
    m_u  = usp_sel_i;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare before the edge, then advance model with the edge
  task automatic cycle(input string force_tag);
    @(negedge clk);
    if (!rst) begin
      check(force_tag != "" ? force_tag : tag_of(ra_size, ra_sel), ra_data, m_read(ra_size, ra_sel));
      check("R9", rb_data, m_read(rb_size, rb_sel));
      check("R5", {31'h0, bank_o}, {31'h0, m_bk});
      check("R8", {31'h0, usp_o}, {31'h0, m_u});
    end
    @(posedge clk);
    m_clock();
    #1;
  endtask

  task automatic drive_wr(input logic en, input logic [1:0] sz, input logic [3:0] s, input logic [31:0] d);
    wr_en = en; wr_size = sz; wr_sel = s; wr_data = d;
  endtask

  task automatic drive_rd(input logic [1:0] asz, input logic [3:0] as, input logic [1:0] bsz, input logic [3:0] bs);
    ra_size = asz; ra_sel = as; rb_size = bsz; rb_sel = bs;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_bk = 0; m_u = 0;
    cycle(""); cycle("");
    rst = 0;
    // R1: everything reads zero after reset, flags cleared
    for (int s = 0; s < 11; s++) begin
      drive_rd(2'd1, 4'(s), 2'd2, 4'(s % 3));
      cycle("R1");
    end
    // R9: write R0 while port A reads it; old value expected
    drive_rd(2'd1, 4'd0, 2'd0, 4'd1);
    drive_wr(1, 2'd1, 4'd0, 32'h0000_1234);
    cycle("R9");
    // R3: byte writes to R0 high and R1 low keep partner bytes
    drive_wr(1, 2'd0, 4'd1, 32'h0000_00AB);
    cycle("R9");
    drive_wr(1, 2'd1, 4'd1, 32'h0000_5566);
    cycle("R2");
    drive_wr(1, 2'd0, 4'd2, 32'h0000_00C3);
    drive_rd(2'd1, 4'd0, 2'd0, 4'd0);
    cycle("R3");
    drive_wr(0, 2'd1, 4'd0, 32'h0);
    drive_rd(2'd1, 4'd1, 2'd0, 4'd3);
    cycle("R3");
    // R4: long write A1:A0 then read back
    drive_wr(1, 2'd2, 4'd2, 32'hDEAD_BEEF);
    cycle("R4");
    drive_wr(0, 2'd1, 4'd0, 32'h0);
    drive_rd(2'd2, 4'd2, 2'd1, 4'd5);
    cycle("R4");
    // R5: write R0 in the same cycle as the bank switch lands in bank 0
    drive_wr(1, 2'd1, 4'd0, 32'h0000_5678);
    bank_sel_i = 1;
    cycle("R5");
    drive_wr(0, 2'd1, 4'd0, 32'h0);
    drive_rd(2'd1, 4'd0, 2'd2, 4'd2);
    cycle("R6");
    // R7: shared SB written in bank 1 visible from bank 0
    drive_wr(1, 2'd1, 4'd7, 32'h0000_7007);
    cycle("R7");
    drive_wr(0, 2'd1, 4'd0, 32'h0);
    bank_sel_i = 0;
    cycle("R6");
    drive_rd(2'd1, 4'd7, 2'd1, 4'd0);
    cycle("R7");
    // R8: active stack pointer write with flag switch in the same cycle
    drive_wr(1, 2'd1, 4'd10, 32'h0000_1515);
    usp_sel_i = 1;
    drive_rd(2'd1, 4'd9, 2'd1, 4'd8);
    cycle("R8");
    drive_wr(1, 2'd1, 4'd10, 32'h0000_2626);
    drive_rd(2'd1, 4'd10, 2'd1, 4'd9);
    cycle("R8");
    drive_wr(0, 2'd1, 4'd0, 32'h0);
    drive_rd(2'd1, 4'd8, 2'd1, 4'd10);
    cycle("R8");
    // R10: invalid size and selectors write nothing and read zero
    drive_wr(1, 2'd3, 4'd0, 32'hFFFF_FFFF);
    drive_rd(2'd3, 4'd0, 2'd0, 4'd9);
    cycle("R10");
    drive_wr(1, 2'd2, 4'd3, 32'hFFFF_FFFF);
    drive_rd(2'd1, 4'd0, 2'd2, 4'd7);
    cycle("R10");
    drive_wr(1, 2'd1, 4'd13, 32'hFFFF_FFFF);
    drive_rd(2'd1, 4'd0, 2'd1, 4'd14);
    cycle("R10");
    drive_wr(0, 2'd1, 4'd0, 32'h0);
    drive_rd(2'd2, 4'd0, 2'd2, 4'd1);
    cycle("R10");
    // random traffic
    for (int n = 0; n < 5000; n++) begin
      rst        = ($urandom_range(0, 299) == 0);
      bank_sel_i = ($urandom_range(0, 5) == 0) ? ~bank_sel_i : bank_sel_i;
      usp_sel_i  = ($urandom_range(0, 7) == 0) ? ~usp_sel_i : usp_sel_i;
      drive_wr($urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
               4'($urandom_range(0, 9) == 0 ? $urandom_range(0, 15) : $urandom_range(0, 10)), $urandom);
      drive_rd(2'($urandom_range(0, 3)), 4'($urandom_range(0, 11)),
               2'($urandom_range(0, 3)), 4'($urandom_range(0, 11)));
      cycle("");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule